// File: doc/BRIEF.md
# Encoded Interrupt Level Slot Decoder

This block turns a 4-bit encoded interrupt level into one-hot request lines for a bank of 15 interrupt source slots. Each slot has two lines that feed a downstream source tracker. One line asks the tracker to raise the slot's request. The other forces the slot's enable on. A level of zero means that no interrupt is requested. Levels 1 to 15 rank from lowest to highest priority. The slot for a level is found by inverting the level bits, so the highest level lands on slot 0.

The slots form an ordered chain. A slot can be reached only if it is configured and every slot below it is configured as well. The configuration is a parameter. The block reports the resulting reach mask on an output. On every update, the selected reachable slot is raised and its enable is latched on. Every other slot is actively dropped. An enable, once forced on, stays on until reset. The level is sampled on each rising clock edge, and the outputs show that sample one edge later. The block does not synchronise the level to the clock and does not arbitrate against other interrupt sources.

Top module: `lvl_irq_decoder`

## Requirements
- R1: While rst_n is low at a rising edge, every bit of src_assert_o and src_enable_o is cleared.
- R2: A sampled level of 0 leaves every bit of src_assert_o at 0 after the next edge.
- R3: A sampled nonzero level L selects slot index L XOR 15, which equals 15 minus L. Level 15 selects bit 0 and level 1 selects bit 14. If that slot is reachable, its src_assert_o bit is 1 after the next edge.
- R4: At most one bit of src_assert_o is 1 at any time.
- R5: When a slot is selected, its src_enable_o bit becomes 1 on the same edge as its assert bit. That enable bit then stays 1 until reset, whatever levels follow.
- R6: On every edge, each slot other than the selected one has its src_assert_o bit driven to 0, including a slot that was asserted on the previous cycle.
- R7: Bit i of slot_live_o is 1 only when configuration bits 0 through i are all 1, because the chain walk stops at the first unconfigured slot. A level that selects an unreachable slot asserts nothing and enables nothing. The bench configuration 15'h77FF leaves slots 0 to 10 reachable and slots 11 to 14 unreachable, even though slots 12 to 14 are configured.
- R8: The outputs change only at a rising edge. A change of level_i between edges leaves the outputs unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| level_i | input | 4 | Encoded interrupt level, where 0 means no request |
| src_assert_o | output | 15 | Per-slot assert request, at most one high |
| src_enable_o | output | 15 | Per-slot forced enable, sticky until reset |
| slot_live_o | output | 15 | Per-slot reach mask produced by the chain walk |

## Verification
The bench builds the block with a 4-bit level and the slot configuration 15'h77FF. This configuration leaves a gap at slot 11 while slots 12 to 14 are still configured. As a result, levels 4 to 1 exercise both kinds of unreachable slot: the unconfigured slot at the gap and the configured slots cut off behind it. Levels 15 to 5 reach live slots 0 to 10. Random level sequences, mixed with directed runs, check that enables stay latched while asserts move between slots, and that the outputs hold steady between edges.

// File: rtl/lvl_dec_pkg.sv
// Package: shared constants and helpers for the encoded level decoder.
// Assumes: levels are unsigned and the slot count is 2**LEVEL_W - 1.
package lvl_dec_pkg;

    localparam int unsigned DEF_LEVEL_W = 4;

    // Number of slots addressed by a level of the given width.
    function automatic int unsigned slots_for_width(input int unsigned w);
        return (1 << w) - 1;
    endfunction

endpackage

// File: rtl/lvl_chain_reach.sv
// Module: walks the configured slot chain from slot 0 upward.
// A slot is live only when it and all lower slots are configured.
// Assumes: SLOT_CFG is static and is fixed at elaboration.
module lvl_chain_reach #(
    parameter int unsigned         NUM_SLOTS = 15,
    parameter logic [NUM_SLOTS-1:0] SLOT_CFG = '1
) (
    output logic [NUM_SLOTS-1:0] live_o
);

    logic [NUM_SLOTS-1:0] reach;

    // Slot 0 starts the chain.
    assign reach[0] = SLOT_CFG[0];

    genvar gi;
    generate
        for (gi = 1; gi < NUM_SLOTS; gi++) begin : g_walk
            // Each slot inherits reachability from the slot below it.
            assign reach[gi] = reach[gi-1] & SLOT_CFG[gi];
        end
    endgenerate

    assign live_o = reach;

endmodule

// File: rtl/lvl_slot_select.sv
// Module: maps an encoded level to a one-hot slot selection.
// A level of zero, or a level whose slot is not live, selects nothing.
// Assumes: NUM_SLOTS == 2**LEVEL_W - 1.
module lvl_slot_select #(
    parameter int unsigned LEVEL_W   = 4,
    parameter int unsigned NUM_SLOTS = 15
) (
    input  logic [LEVEL_W-1:0]   level_i,
    input  logic [NUM_SLOTS-1:0] live_i,
    output logic [NUM_SLOTS-1:0] sel_o
);

    localparam logic [LEVEL_W-1:0] ALL_ONES = '1;

    logic [LEVEL_W-1:0] slot_idx;
    logic               req;

    // Inverting the level bits gives the slot index.
    assign slot_idx = level_i ^ ALL_ONES;
    assign req      = (level_i != '0);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SLOTS; gi++) begin : g_hit
            // A slot is hit when it is addressed, requested and live.
            assign sel_o[gi] = req && live_i[gi] &&
                               (slot_idx == LEVEL_W'(gi));
        end
    endgenerate

endmodule

// File: rtl/lvl_slot_bank.sv
// Module: per-slot assert and sticky enable registers.
// Each update raises the selected slot and drops all the others.
// Assumes: sel_i is one-hot or zero, with synchronous active-low reset.
module lvl_slot_bank #(
    parameter int unsigned NUM_SLOTS = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] sel_i,
    input  logic [NUM_SLOTS-1:0] live_i,
    output logic [NUM_SLOTS-1:0] assert_o,
    output logic [NUM_SLOTS-1:0] enable_o
);

    logic [NUM_SLOTS-1:0] asrt_q;
    logic [NUM_SLOTS-1:0] en_q;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SLOTS; gi++) begin : g_slot
            // Assert follows the selection; a non-selected slot is dropped.
            always_ff @(posedge clk) begin
                if (!rst_n) asrt_q[gi] <= 1'b0;
                else        asrt_q[gi] <= sel_i[gi];
            end

            // The enable is forced on at selection and kept until reset.
            always_ff @(posedge clk) begin
                if (!rst_n)         en_q[gi] <= 1'b0;
                else if (sel_i[gi]) en_q[gi] <= 1'b1;
            end

            p_enable_sticky_r5: assert property (@(posedge clk)
                disable iff (!rst_n) en_q[gi] |=> en_q[gi]);

            p_assert_has_enable_r5: assert property (@(posedge clk)
                disable iff (!rst_n) asrt_q[gi] |-> en_q[gi]);

            p_dead_slot_quiet_r7: assert property (@(posedge clk)
                disable iff (!rst_n) !live_i[gi] |-> !(asrt_q[gi] || en_q[gi]));
        end
    endgenerate

    p_single_assert_r4: assert property (@(posedge clk)
        disable iff (!rst_n) $onehot0(asrt_q));

    assign assert_o = asrt_q;
    assign enable_o = en_q;

endmodule

// File: rtl/lvl_irq_decoder.sv
// Module: top of the encoded interrupt level slot decoder.
// The level is sampled on each rising edge and the slot outputs are registered.
// Assumes: level_i is already synchronous to clk; reset is synchronous and active low.
module lvl_irq_decoder
    import lvl_dec_pkg::*;
#(
    parameter int unsigned LEVEL_W = DEF_LEVEL_W,
    parameter int unsigned NUM_SLOTS = slots_for_width(LEVEL_W),
    parameter logic [NUM_SLOTS-1:0] SLOT_CFG = '1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LEVEL_W-1:0]   level_i,
    output logic [NUM_SLOTS-1:0] src_assert_o,
    output logic [NUM_SLOTS-1:0] src_enable_o,
    output logic [NUM_SLOTS-1:0] slot_live_o
);

    logic [NUM_SLOTS-1:0] live;
    logic [NUM_SLOTS-1:0] sel;

    lvl_chain_reach #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_CFG  (SLOT_CFG)
    ) u_reach (
        .live_o (live)
    );

    lvl_slot_select #(
        .LEVEL_W   (LEVEL_W),
        .NUM_SLOTS (NUM_SLOTS)
    ) u_select (
        .level_i (level_i),
        .live_i  (live),
        .sel_o   (sel)
    );

    lvl_slot_bank #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (sel),
        .live_i   (live),
        .assert_o (src_assert_o),
        .enable_o (src_enable_o)
    );

    assign slot_live_o = live;

    p_idle_level_r2: assert property (@(posedge clk)
        disable iff (!rst_n) (level_i == '0) |=> (src_assert_o == '0));

    p_top_level_slot0_r3: assert property (@(posedge clk)
        disable iff (!rst_n) (level_i == '1) |=> (src_assert_o[0] == slot_live_o[0]));

    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (src_assert_o == '0 && src_enable_o == '0));

endmodule

// File: tb/test_lvl_irq_decoder.sv
module test_lvl_irq_decoder;

    localparam int unsigned LW = 4;
    localparam int unsigned NS = 15;
    localparam logic [NS-1:0] CFG = 15'h77FF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [LW-1:0] level = '0;
    logic [NS-1:0] src_assert, src_enable, slot_live;

    lvl_irq_decoder #(.LEVEL_W(LW), .NUM_SLOTS(NS), .SLOT_CFG(CFG)) i_lvl_irq_decoder (
        .clk(clk), .rst_n(rst_n), .level_i(level),
        .src_assert_o(src_assert), .src_enable_o(src_enable), .slot_live_o(slot_live)
    );

    always #10 clk = ~clk;  // 50 MHz

    int unsigned n_chk = 0;
    int unsigned n_err = 0;
    logic [NS-1:0] exp_asrt = '0;
    logic [NS-1:0] exp_en = '0;
    logic [NS-1:0] ref_live;

    // Reference reach mask: stop at the first unconfigured slot.
    function automatic logic [NS-1:0] calc_live();
        logic [NS-1:0] m = '0;
        for (int i = 0; i < NS; i++) begin
            if (!CFG[i]) break;
            m[i] = 1'b1;
        end
        return m;
    endfunction

    // Reference slot for a level, or -1 when nothing is selected.
    function automatic int calc_slot(input logic [LW-1:0] lv);
        int s;
        if (lv == 0) return -1;
        s = 15 - int'(lv);
        if (!ref_live[s]) return -1;
        return s;
    endfunction

    task automatic check(input string req, input logic [NS-1:0] act, input logic [NS-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // Drive a level at a falling edge, advance one edge, then compare.
    task automatic step(input logic [LW-1:0] lv);
        int s;
        level = lv;
        #2;
        check("R8 hold between edges", src_assert, exp_asrt);
        @(posedge clk);
        s = calc_slot(lv);
        if (rst_n) begin
            exp_asrt = '0;
            if (s >= 0) begin
                exp_asrt[s] = 1'b1;
                exp_en[s]   = 1'b1;
            end
        end else begin
            exp_asrt = '0;
            exp_en   = '0;
        end
        @(negedge clk);
        if (lv == 0)      check("R2 idle level", src_assert, exp_asrt);
        else if (s < 0)   check("R7 unreachable slot", src_assert, exp_asrt);
        else              check("R3 R6 slot select", src_assert, exp_asrt);
        check("R5 enable", src_enable, exp_en);
        n_chk++;
        if ($countones(src_assert) > 1) begin
            n_err++;
            $display("FAIL R4 onehot: actual=%h expected=at most one bit", src_assert);
        end
    endtask

    initial begin
        #(20 * 150000);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed));
        ref_live = calc_live();
        level = 4'd15;
        repeat (3) @(negedge clk);
        check("R1 reset assert", src_assert, '0);
        check("R1 reset enable", src_enable, '0);
        check("R7 live mask", slot_live, ref_live);
        rst_n = 1'b1;
        // Directed corners.
        step(4'd0);
        step(4'd15);   // slot 0
        step(4'd1);    // slot 14, configured but cut off
        step(4'd5);    // slot 10, last live
        step(4'd4);    // slot 11, the gap
        step(4'd3);    // slot 12, configured but unreachable
        step(4'd14);
        step(4'd14);
        step(4'd0);
        // Random levels.
        for (int i = 0; i < 400; i++) step(4'($urandom_range(0, 15)));
        // Reset in the middle of the run clears the sticky enables.
        rst_n = 1'b0;
        step(4'd9);
        check("R1 mid reset assert", src_assert, '0);
        check("R1 mid reset enable", src_enable, '0);
        rst_n = 1'b1;
        for (int i = 0; i < 100; i++) step(4'($urandom_range(0, 15)));
        finish_run();
    end

endmodule